// File: doc/BRIEF.md
# Landing-Pad Expected-State Tracker

This block keeps the one-bit "landing pad expected" flag of a processor hart. When an indirect jump retires, the flag is raised if forward-edge protection is on in the current mode. It also holds five saved copies of that flag. One is saved when a trap is taken into M, into HS and into VS, one on debug-mode entry, and one on resumable-NMI entry. Each entry event captures the live flag into its copy and clears the live flag. Each return event brings the copy back, but only when the landing-pad enable of the mode being returned to is set.

The per-mode enable bits come from the configuration registers. The block selects the one that applies to the current mode and drives it out. It uses the same selection for the privilege named by a return. A small register-style port reads and writes the saved copies. A handler can then spill and restore them around nested traps.

Top module: `lp_state_tracker`

## Requirements
- R1: After reset the live flag is 0 (0 means no landing pad expected, 1 means one is expected), and all five saved copies are 0.
- R2: The privilege code is 3 for M, 1 for S and 0 for U, and the current enable is selected from it. With S-mode present, M uses the M-mode enable bit and non-virtual S uses the machine-level environment bit. Virtual S uses the hypervisor-level environment bit, and U uses the supervisor-level environment bit whether virtual or not.
- R3: Built without S-mode, M still uses the M-mode enable bit and every other privilege uses the machine-level environment bit.
- R4: A trap strobe with target code 0 (M), 1 (HS) or 2 (VS) copies the live flag into slot 0, 1 or 2 respectively. Code 3 acts as M. The live flag reads 0 after that edge.
- R5: Debug entry copies the live flag into slot 3, NMI entry copies it into slot 4, and both clear the live flag.
- R6: A trap return naming slot code 0, 1 or 2 sets the live flag to that slot ANDed with the enable of the return privilege and virtualization, and clears that slot.
- R7: Debug resume and NMI return set the live flag to slot 3 or slot 4 respectively, ANDed with the enable of the return mode. The slot keeps its value.
- R8: The jump-set pulse raises the live flag only when the current enable is 1. Otherwise it leaves the flag unchanged.
- R9: When strobes coincide, entries beat returns and returns beat the jump-set pulse. Among entries NMI beats debug and debug beats trap. Among returns NMI return beats debug resume and debug resume beats trap return.
- R10: Select values 0 to 4 read their slot combinationally, and select values 5 to 7 read 0 and ignore writes. A write lands at the next edge, but an entry or trap return touching the same slot in that cycle wins over it.
- R11: With no event and no effective set pulse, the live flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_virt_i | input | 1 | Current virtualization mode |
| cfg_m_lpe_i | input | 1 | M-mode landing-pad enable |
| cfg_menv_lpe_i | input | 1 | Machine-level environment enable |
| cfg_henv_lpe_i | input | 1 | Hypervisor-level environment enable |
| cfg_senv_lpe_i | input | 1 | Supervisor-level environment enable |
| jump_set_i | input | 1 | Indirect jump retired: expect a landing pad |
| trap_i | input | 1 | Trap taken |
| trap_tgt_i | input | 2 | Trap target (0 M, 1 HS, 2 VS) |
| xret_i | input | 1 | Trap return executed |
| xret_src_i | input | 2 | Slot the return uses (0 M, 1 S, 2 VS) |
| dbg_enter_i | input | 1 | Debug-mode entry |
| dbg_resume_i | input | 1 | Debug-mode resume |
| nmi_enter_i | input | 1 | Resumable NMI taken |
| nmi_ret_i | input | 1 | Return from NMI handler |
| ret_priv_i | input | 2 | Privilege named by the current return |
| ret_virt_i | input | 1 | Virtualization named by the current return |
| csr_we_i | input | 1 | Slot write strobe |
| csr_sel_i | input | 3 | Slot select |
| csr_wdata_i | input | 1 | Slot write data |
| csr_rdata_o | output | 1 | Selected slot value |
| elp_o | output | 1 | Live landing-pad-expected flag |
| pelp_o | output | 5 | All saved copies, bit k is slot k |
| lpe_cur_o | output | 1 | Enable for the current mode |

## Verification
The live flag and the saved copies change on the clock edge after a strobe, so each is due one cycle later. The selected enable and the slot read data are combinational and are due in the same cycle. The bench drives inputs on the falling edge and checks the combinational outputs 1 ns later, against a model state that has not yet been stepped. It then steps its model and compares the registered outputs at the next falling edge, one full cycle after the strobe. A second instance built without S-mode is checked against the reduced enable selection.

// File: rtl/lpt_pkg.sv
`timescale 1ns/1ps
package lpt_pkg;
  localparam int unsigned NSLOT  = 5;
  localparam int unsigned SLOT_W = $clog2(NSLOT + 1);

  localparam int unsigned SLOT_M   = 0;
  localparam int unsigned SLOT_S   = 1;
  localparam int unsigned SLOT_VS  = 2;
  localparam int unsigned SLOT_DBG = 3;
  localparam int unsigned SLOT_NMI = 4;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef struct packed {
    logic m_lpe;
    logic menv_lpe;
    logic henv_lpe;
    logic senv_lpe;
  } lpe_cfg_t;

  // Enable selection when S-mode exists
  function automatic logic full_mode_lpe(input logic [1:0] priv, input logic virt,
                                         input lpe_cfg_t c, input bit has_h);
    if (priv == PRIV_M) return c.m_lpe;
    if (priv == PRIV_S) return (virt && has_h) ? c.henv_lpe : c.menv_lpe;
    return c.senv_lpe;
  endfunction

  // Enable selection for an M/U-only hart
  function automatic logic mu_mode_lpe(input logic [1:0] priv, input lpe_cfg_t c);
    return (priv == PRIV_M) ? c.m_lpe : c.menv_lpe;
  endfunction

  // Map a trap target / return source code to its slot index
  function automatic logic [SLOT_W-1:0] tgt_to_slot(input logic [1:0] code);
    case (code)
      2'd1:    return SLOT_W'(SLOT_S);
      2'd2:    return SLOT_W'(SLOT_VS);
      default: return SLOT_W'(SLOT_M);
    endcase
  endfunction
endpackage

// File: rtl/lpt_enable_sel.sv
`timescale 1ns/1ps
module lpt_enable_sel
  import lpt_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_HYP   = 1'b1
) (
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  lpe_cfg_t   cfg_i,
  output logic       lpe_o
);
  generate
    if (HAS_SMODE) begin : g_with_s
      assign lpe_o = full_mode_lpe(priv_i, virt_i, cfg_i, HAS_HYP);
    end else begin : g_mu_only
      logic unused_virt;
      assign unused_virt = virt_i;
      assign lpe_o = mu_mode_lpe(priv_i, cfg_i);
    end
  endgenerate
endmodule

// File: rtl/lpt_event_decode.sv
`timescale 1ns/1ps
module lpt_event_decode
  import lpt_pkg::*;
(
  input  logic             trap_i,
  input  logic [1:0]       trap_tgt_i,
  input  logic             xret_i,
  input  logic [1:0]       xret_src_i,
  input  logic             dbg_enter_i,
  input  logic             dbg_resume_i,
  input  logic             nmi_enter_i,
  input  logic             nmi_ret_i,
  output logic [NSLOT-1:0] save_vec_o,
  output logic [NSLOT-1:0] rest_vec_o,
  output logic [NSLOT-1:0] clr_vec_o,
  output logic             any_entry_o,
  output logic             any_ret_o
);
  logic ev_nmi, ev_dbg, ev_trap, ev_mnret, ev_resume, ev_xret;
  logic [SLOT_W-1:0] trap_slot, xret_slot;

  // Entry priority: NMI, then debug, then trap
  assign ev_nmi  = nmi_enter_i;
  assign ev_dbg  = dbg_enter_i & ~nmi_enter_i;
  assign ev_trap = trap_i & ~nmi_enter_i & ~dbg_enter_i;
  assign any_entry_o = ev_nmi | ev_dbg | ev_trap;

  // Returns only when no entry; NMI return, then resume, then trap return
  assign ev_mnret  = nmi_ret_i & ~any_entry_o;
  assign ev_resume = dbg_resume_i & ~any_entry_o & ~nmi_ret_i;
  assign ev_xret   = xret_i & ~any_entry_o & ~nmi_ret_i & ~dbg_resume_i;
  assign any_ret_o = ev_mnret | ev_resume | ev_xret;

  assign trap_slot = tgt_to_slot(trap_tgt_i);
  assign xret_slot = tgt_to_slot(xret_src_i);

  always_comb begin
    save_vec_o = '0;
    rest_vec_o = '0;
    clr_vec_o  = '0;
    if (ev_trap) save_vec_o[trap_slot] = 1'b1;
    save_vec_o[SLOT_DBG] = ev_dbg;
    save_vec_o[SLOT_NMI] = ev_nmi;
    if (ev_xret) begin
      rest_vec_o[xret_slot] = 1'b1;
      clr_vec_o[xret_slot]  = 1'b1;
    end
    rest_vec_o[SLOT_DBG] = ev_resume;
    rest_vec_o[SLOT_NMI] = ev_mnret;
  end
endmodule

// File: rtl/lpt_slot_bank.sv
`timescale 1ns/1ps
module lpt_slot_bank
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              elp_i,
  input  logic [NSLOT-1:0]  save_vec_i,
  input  logic [NSLOT-1:0]  clr_vec_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_sel_i,
  input  logic              wr_data_i,
  output logic [NSLOT-1:0]  slot_o
);
  generate
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      logic hit;
      assign hit = wr_en_i && (wr_sel_i == SLOT_W'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             slot_o[k] <= 1'b0;
        else if (save_vec_i[k]) slot_o[k] <= elp_i;
        else if (clr_vec_i[k])  slot_o[k] <= 1'b0;
        else if (hit)           slot_o[k] <= wr_data_i;
      end
    end
  endgenerate
endmodule

// File: rtl/lpt_elp_core.sv
`timescale 1ns/1ps
module lpt_elp_core
  import lpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_entry_i,
  input  logic             any_ret_i,
  input  logic [NSLOT-1:0] rest_vec_i,
  input  logic [NSLOT-1:0] slot_i,
  input  logic             ret_lpe_i,
  input  logic             set_i,
  input  logic             cur_lpe_i,
  output logic             elp_o
);
  logic restored, elp_nxt;
  assign restored = |(rest_vec_i & slot_i);

  always_comb begin
    elp_nxt = elp_o;
    if (any_entry_i)            elp_nxt = 1'b0;
    else if (any_ret_i)         elp_nxt = restored & ret_lpe_i;
    else if (set_i & cur_lpe_i) elp_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elp_o <= 1'b0;
    else        elp_o <= elp_nxt;
  end
endmodule

// File: rtl/lp_state_tracker.sv
`timescale 1ns/1ps
module lp_state_tracker
  import lpt_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_HYP   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cur_priv_i,
  input  logic        cur_virt_i,
  input  logic        cfg_m_lpe_i,
  input  logic        cfg_menv_lpe_i,
  input  logic        cfg_henv_lpe_i,
  input  logic        cfg_senv_lpe_i,
  input  logic        jump_set_i,
  input  logic        trap_i,
  input  logic [1:0]  trap_tgt_i,
  input  logic        xret_i,
  input  logic [1:0]  xret_src_i,
  input  logic        dbg_enter_i,
  input  logic        dbg_resume_i,
  input  logic        nmi_enter_i,
  input  logic        nmi_ret_i,
  input  logic [1:0]  ret_priv_i,
  input  logic        ret_virt_i,
  input  logic        csr_we_i,
  input  logic [2:0]  csr_sel_i,
  input  logic        csr_wdata_i,
  output logic        csr_rdata_o,
  output logic        elp_o,
  output logic [4:0]  pelp_o,
  output logic        lpe_cur_o
);
  lpe_cfg_t         cfg;
  logic             cur_lpe, ret_lpe, any_entry, any_ret;
  logic [NSLOT-1:0] save_vec, rest_vec, clr_vec, slots;
  logic [SLOT_W-1:0] sel;

  assign cfg = '{m_lpe: cfg_m_lpe_i, menv_lpe: cfg_menv_lpe_i,
                 henv_lpe: cfg_henv_lpe_i, senv_lpe: cfg_senv_lpe_i};
  assign sel = SLOT_W'(csr_sel_i);

  lpt_enable_sel #(.HAS_SMODE(HAS_SMODE), .HAS_HYP(HAS_HYP)) u_cur_en (
    .priv_i(cur_priv_i), .virt_i(cur_virt_i), .cfg_i(cfg), .lpe_o(cur_lpe));

  lpt_enable_sel #(.HAS_SMODE(HAS_SMODE), .HAS_HYP(HAS_HYP)) u_ret_en (
    .priv_i(ret_priv_i), .virt_i(ret_virt_i), .cfg_i(cfg), .lpe_o(ret_lpe));

  lpt_event_decode u_dec (
    .trap_i(trap_i), .trap_tgt_i(trap_tgt_i), .xret_i(xret_i), .xret_src_i(xret_src_i),
    .dbg_enter_i(dbg_enter_i), .dbg_resume_i(dbg_resume_i),
    .nmi_enter_i(nmi_enter_i), .nmi_ret_i(nmi_ret_i),
    .save_vec_o(save_vec), .rest_vec_o(rest_vec), .clr_vec_o(clr_vec),
    .any_entry_o(any_entry), .any_ret_o(any_ret));

  lpt_slot_bank u_bank (
    .clk(clk), .rst_n(rst_n), .elp_i(elp_o), .save_vec_i(save_vec), .clr_vec_i(clr_vec),
    .wr_en_i(csr_we_i), .wr_sel_i(sel), .wr_data_i(csr_wdata_i), .slot_o(slots));

  lpt_elp_core u_core (
    .clk(clk), .rst_n(rst_n), .any_entry_i(any_entry), .any_ret_i(any_ret),
    .rest_vec_i(rest_vec), .slot_i(slots), .ret_lpe_i(ret_lpe), .set_i(jump_set_i),
    .cur_lpe_i(cur_lpe), .elp_o(elp_o));

  assign csr_rdata_o = (sel < SLOT_W'(NSLOT)) ? slots[sel] : 1'b0;
  assign pelp_o      = slots;
  assign lpe_cur_o   = cur_lpe;
endmodule

// File: rtl/lpt_checker.sv
`timescale 1ns/1ps
module lpt_checker
  import lpt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             elp_o,
  input logic [NSLOT-1:0] pelp_o,
  input logic [NSLOT-1:0] save_vec,
  input logic [NSLOT-1:0] rest_vec,
  input logic [NSLOT-1:0] clr_vec,
  input logic             any_entry,
  input logic             any_ret,
  input logic             ret_lpe,
  input logic             cur_lpe,
  input logic             jump_set_i
);
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!elp_o && pelp_o == '0));

  assert_entry_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_entry |=> !elp_o);

  assert_one_save_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(save_vec) && $onehot0(rest_vec));

  assert_gated_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ret && !ret_lpe) |=> !elp_o);

  assert_set_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_entry && !any_ret && jump_set_i && cur_lpe) |=> elp_o);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_entry && !any_ret && !(jump_set_i && cur_lpe)) |=> $stable(elp_o));

  generate
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot_chk
      assert_save_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
        save_vec[k] |=> (pelp_o[k] == $past(elp_o)));
      assert_return_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vec[k] |=> !pelp_o[k]);
      assert_restore_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rest_vec[k] && any_ret) |=> (elp_o == ($past(pelp_o[k]) && $past(ret_lpe))));
    end
  endgenerate
endmodule

bind lp_state_tracker lpt_checker u_lpt_chk (
  .clk(clk), .rst_n(rst_n), .elp_o(elp_o), .pelp_o(pelp_o),
  .save_vec(save_vec), .rest_vec(rest_vec), .clr_vec(clr_vec),
  .any_entry(any_entry), .any_ret(any_ret), .ret_lpe(ret_lpe),
  .cur_lpe(cur_lpe), .jump_set_i(jump_set_i));

// File: tb/lp_state_tracker_test.sv
`timescale 1ns/1ps
module lp_state_tracker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] cur_priv, trap_tgt, xret_src, ret_priv;
  logic cur_virt, ret_virt, c_m, c_menv, c_henv, c_senv;
  logic jset, trap, xret, dent, dres, nent, nret, we, wdata;
  logic [2:0] sel;
  logic rdata, elp, lcur, rdata_n, elp_n, lcur_n;
  logic [4:0] pelp, pelp_n;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic       em;
  logic [4:0] pm;

  lp_state_tracker uut (
    .clk(clk), .rst_n(rst_n), .cur_priv_i(cur_priv), .cur_virt_i(cur_virt),
    .cfg_m_lpe_i(c_m), .cfg_menv_lpe_i(c_menv), .cfg_henv_lpe_i(c_henv), .cfg_senv_lpe_i(c_senv),
    .jump_set_i(jset), .trap_i(trap), .trap_tgt_i(trap_tgt), .xret_i(xret), .xret_src_i(xret_src),
    .dbg_enter_i(dent), .dbg_resume_i(dres), .nmi_enter_i(nent), .nmi_ret_i(nret),
    .ret_priv_i(ret_priv), .ret_virt_i(ret_virt), .csr_we_i(we), .csr_sel_i(sel),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .elp_o(elp), .pelp_o(pelp), .lpe_cur_o(lcur));

  lp_state_tracker #(.HAS_SMODE(1'b0)) uut_nos (
    .clk(clk), .rst_n(rst_n), .cur_priv_i(cur_priv), .cur_virt_i(cur_virt),
    .cfg_m_lpe_i(c_m), .cfg_menv_lpe_i(c_menv), .cfg_henv_lpe_i(c_henv), .cfg_senv_lpe_i(c_senv),
    .jump_set_i(jset), .trap_i(trap), .trap_tgt_i(trap_tgt), .xret_i(xret), .xret_src_i(xret_src),
    .dbg_enter_i(dent), .dbg_resume_i(dres), .nmi_enter_i(nent), .nmi_ret_i(nret),
    .ret_priv_i(ret_priv), .ret_virt_i(ret_virt), .csr_we_i(we), .csr_sel_i(sel),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata_n), .elp_o(elp_n), .pelp_o(pelp_n), .lpe_cur_o(lcur_n));

  // Enable table restated from R2 / R3
  function automatic logic want_lpe(input logic [1:0] p, input logic v, input bit has_s);
    case (p)
      2'd3:    return c_m;
      2'd1:    return !has_s ? c_menv : (v ? c_henv : c_menv);
      default: return has_s ? c_senv : c_menv;
    endcase
  endfunction

  function automatic int code_slot(input logic [1:0] code);
    return (code == 2'd1 || code == 2'd2) ? int'(code) : 0;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string rq, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {jset, trap, xret, dent, dres, nent, nret, we, wdata} = '0;
    trap_tgt = 2'd0; xret_src = 2'd0; sel = 3'd0;
  endtask

  // Inputs were set at a falling edge; check comb outputs, step model, check regs next fall
  task automatic step(input string rq);
    logic       ne;
    logic [4:0] np;
    logic       rl;
    int s;
    #1;
    chk({7'd0, lcur}, {7'd0, want_lpe(cur_priv, cur_virt, 1)}, "R2", "current enable");
    chk({7'd0, lcur_n}, {7'd0, want_lpe(cur_priv, cur_virt, 0)}, "R3", "enable without S");
    chk({7'd0, rdata}, {7'd0, (sel < 3'd5) ? pm[sel] : 1'b0}, "R10", "slot read");
    rl = want_lpe(ret_priv, ret_virt, 1);
    ne = em; np = pm;
    if (we && sel < 3'd5) np[sel] = wdata;
    if (nent)      begin np[4] = em; ne = 1'b0; end
    else if (dent) begin np[3] = em; ne = 1'b0; end
    else if (trap) begin np[code_slot(trap_tgt)] = em; ne = 1'b0; end
    else if (nret) ne = pm[4] & rl;
    else if (dres) ne = pm[3] & rl;
    else if (xret) begin s = code_slot(xret_src); ne = pm[s] & rl; np[s] = 1'b0; end
    else if (jset && want_lpe(cur_priv, cur_virt, 1)) ne = 1'b1;
    em = ne; pm = np;
    @(negedge clk);
    chk({7'd0, elp}, {7'd0, em}, rq, "live flag");
    chk({3'd0, pelp}, {3'd0, pm}, rq, "saved slots");
    idle_inputs();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    idle_inputs();
    cur_priv = 2'd0; cur_virt = 0; ret_priv = 2'd0; ret_virt = 0;
    {c_m, c_menv, c_henv, c_senv} = 4'b1111;
    em = 0; pm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state via outputs and every slot read
    chk({7'd0, elp}, 8'd0, "R1", "live flag after reset");
    chk({3'd0, pelp}, 8'd0, "R1", "slots after reset");
    for (int k = 0; k < 8; k++) begin
      sel = 3'(k); #1; chk({7'd0, rdata}, 8'd0, "R1", "slot read after reset");
      @(negedge clk);
    end
    idle_inputs();

    // R8: set pulse in U with enable 1, then ignored with enable 0
    jset = 1; step("R8");
    trap = 1; trap_tgt = 2'd1; step("R4");           // HS slot gets 1
    c_senv = 0; jset = 1; step("R8");                // ignored, flag stays 0
    c_senv = 1;
    // R9: trap and set pulse together; trap wins and saves the old flag
    jset = 1; step("R8");
    trap = 1; jset = 1; trap_tgt = 2'd0; step("R9");
    // R6: return to U with its enable off gives 0 and clears slot
    ret_priv = 2'd0; c_senv = 0; xret = 1; xret_src = 2'd0; step("R6");
    c_senv = 1;
    // R6: return with enable on restores the HS slot
    ret_priv = 2'd0; xret = 1; xret_src = 2'd1; step("R6");
    // R5 / R7: debug round trip keeps slot
    dent = 1; step("R5");
    ret_priv = 2'd3; c_m = 1; dres = 1; step("R7");
    nent = 1; step("R5");
    ret_priv = 2'd3; c_m = 0; nret = 1; step("R7");
    c_m = 1;
    // R10: write a slot, then entry and write to same slot together
    we = 1; sel = 3'd2; wdata = 1; step("R10");
    we = 1; sel = 3'd6; wdata = 1; step("R10");
    we = 1; sel = 3'd3; wdata = 1; dent = 1; step("R10");
    // R4: target code 3 acts as M
    jset = 1; step("R8");
    trap = 1; trap_tgt = 2'd3; step("R4");
    // R3: M/U hart picks machine-level bit for U
    cur_priv = 2'd0; c_menv = 0; c_senv = 1; step("R3");
    c_menv = 1;

    // Random mix (R9, R11 included)
    for (int i = 0; i < 3000; i++) begin
      int r;
      {c_m, c_menv, c_henv, c_senv} = 4'($urandom);
      r = $urandom % 3; cur_priv = (r == 0) ? 2'd0 : (r == 1) ? 2'd1 : 2'd3;
      cur_virt = 1'($urandom); ret_virt = 1'($urandom);
      r = $urandom % 3; ret_priv = (r == 0) ? 2'd0 : (r == 1) ? 2'd1 : 2'd3;
      trap_tgt = 2'($urandom); xret_src = 2'($urandom);
      if ($urandom % 4 == 0) begin we = 1; sel = 3'($urandom); wdata = 1'($urandom); end
      else sel = 3'($urandom);
      r = $urandom % 16;
      case (r)
        0: trap = 1;  1: xret = 1;  2: dent = 1;  3: dres = 1;
        4: nent = 1;  5: nret = 1;  6, 7, 8, 9: jset = 1;
        10: begin trap = 1; jset = 1; end
        11: {nent, dent, trap, nret, dres, xret, jset} = 7'($urandom);
        default: ;
      endcase
      step("R11");
    end
    summary();
  end
endmodule